// File: doc/BRIEF.md
# Message-In Byte Queue

This block holds the message bytes that a target hands to the initiator while the bus sits in the message-in phase. Bytes enter through a single write path, either from a direct push port or from a small sequencer that writes fixed message sequences on request. A status request writes the command-complete byte. A defer request, for a command that cannot finish at once, writes a save-pointer byte and then a disconnect byte. Each accepted byte also records a 2-bit action code. When the queue drains, that code selects the next bus phase.

A consumer asks for a transfer of up to `xfer_len` bytes. The block streams the smaller of that count and the queue level, one byte per cycle and oldest first. It then spends one cycle in a done state that reports how many bytes moved. When the queue is empty at that point, it also raises a phase-select strobe. Two snoop values are held for software: a copy of the head byte taken when a transfer starts, and a latch of the last byte moved. A bus-data port shows the head byte only during the message-in phase.

The sequencer has four states. IDLE accepts requests. DEFER2 writes the second byte of a defer sequence. XFER streams bytes. DONE reports the result. The transitions are: IDLE to DEFER2 on a defer request; IDLE to XFER on a transfer request with a nonzero take; IDLE to DONE on a transfer request with a zero take; DEFER2 to IDLE; XFER to DONE when the last byte leaves; and DONE to IDLE.

Top module: `msgin_queue`

## Requirements
- R1: The queue holds at most DEPTH (8) bytes. A write attempted while the level is 8 is dropped, the level is unchanged, and `overflow` pulses high for one cycle, one cycle after the attempt.
- R2: A transfer request accepted in IDLE moves take = min(`xfer_len`, level) bytes. `out_valid` is high for exactly take cycles, starting the cycle after the request. In the cycle that follows, `xfer_done` is high for one cycle and `moved` equals take. A take of 0 gives `xfer_done` the cycle after the request.
- R3: Bytes leave in the order they were written. After each byte leaves, the remaining bytes move down so the next unsent byte is at entry 0. Vacated entries read as zero.
- R4: `last_byte` captures the final byte of every nonzero transfer. A transfer with take 0 leaves it unchanged.
- R5: `bus_data` equals entry 0 while `msgin_phase` is 1 and reads 0 otherwise. An empty queue has entry 0 equal to 0.
- R6: `phase_valid` is high only in the done cycle, and only when the queue level is 0 in that cycle. `next_phase` then gives the action code: 0 = command, 1 = disconnect, 2 = data out, 3 = data in.
- R7: A status request in IDLE writes byte 0x00 with action 1.
- R8: A defer request in IDLE writes byte 0x02 with action 1, then byte 0x04 with action 1 in the next cycle, in state DEFER2.
- R9: `first_byte` takes the value of entry 0 in the cycle a transfer request is accepted. That value is 0 if the queue is empty.
- R10: After reset, the level is 0, the action is 0 (command), `first_byte` and `last_byte` are 0, and all strobes are low.
- R11: In IDLE, a defer request outranks a status request, which outranks a transfer request. The lower-ranked requests in that cycle have no effect. In any cycle where the sequencer writes a byte, the direct push is ignored. Requests that arrive outside IDLE are ignored.
- R12: A direct push is accepted in IDLE, XFER and DONE, including the cycle of a transfer request or of any XFER cycle. It is appended behind the bytes still queued. The full test uses the level at the start of that cycle.
- R13: Every accepted write replaces the stored action code with the code written alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Direct write of one byte |
| push_byte | input | W | Byte to write |
| push_action | input | 2 | Action code written with the byte |
| status_req | input | 1 | Write the command-complete sequence |
| defer_req | input | 1 | Write the save-pointer and disconnect sequence |
| xfer_req | input | 1 | Request a transfer |
| xfer_len | input | LENW | Requested byte count |
| msgin_phase | input | 1 | Bus is in the message-in phase |
| out_valid | output | 1 | A transferred byte is on `out_byte` |
| out_byte | output | W | Transferred byte |
| xfer_done | output | 1 | Done cycle of a transfer |
| moved | output | LVLW | Bytes moved by the finished transfer |
| phase_valid | output | 1 | Queue drained; `next_phase` is valid |
| next_phase | output | 2 | Stored action code |
| first_byte | output | W | Head byte copied at transfer start |
| last_byte | output | W | Last byte moved |
| bus_data | output | W | Head byte during message-in, otherwise 0 |
| level | output | LVLW | Bytes queued |
| overflow | output | 1 | A write was dropped because the queue was full |

## Verification
The two functions that can fall in the same cycle are a direct push and a transfer. The push can arrive in the request cycle or in any streaming cycle, and in a streaming cycle it lands in a slot that is being vacated by the shift. The bench provokes this with directed runs on a full queue and an empty queue, and with random pushes inside random-length transfers. A reference queue, kept one cycle at a time, judges every streamed byte, the level, the overflow pulse and the action code. The same collision between the sequencer and a direct push is checked by asserting both in one cycle and confirming that only the sequencer byte appears in the level and in the stream.

// File: rtl/msgin_pkg.sv
package msgin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DEFER2 = 2'd1,
        ST_XFER   = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;

    localparam logic [7:0] MSG_COMPLETE = 8'h00;
    localparam logic [7:0] MSG_SAVE_PTR = 8'h02;
    localparam logic [7:0] MSG_DISCONN  = 8'h04;

    localparam logic [1:0] ACT_COMMAND  = 2'd0;
    localparam logic [1:0] ACT_DISCONN  = 2'd1;
    localparam logic [1:0] ACT_DATA_OUT = 2'd2;
    localparam logic [1:0] ACT_DATA_IN  = 2'd3;
endpackage

// File: rtl/msgin_store.sv
module msgin_store #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int LVLW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [W-1:0]    wr_byte,
    input  logic            shift,
    output logic [LVLW-1:0] level,
    output logic [W-1:0]    head,
    output logic            accepted,
    output logic            ovf
);
    logic [W-1:0]    ent_q [DEPTH];
    logic [W-1:0]    ent_d [DEPTH];
    logic [LVLW-1:0] level_q;
    logic [LVLW-1:0] widx;
    logic            full;
    logic            ovf_q;

    assign full     = (level_q == LVLW'(DEPTH));
    assign accepted = wr_en && !full;
    // with a shift in the same cycle the write lands one slot lower
    assign widx     = shift ? (level_q - LVLW'(1)) : level_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [W-1:0] moved_in;
        if (i == DEPTH - 1) begin : g_top
            assign moved_in = '0;
        end else begin : g_mid
            assign moved_in = ent_q[i+1];
        end
        always_comb begin
            if (accepted && (widx == LVLW'(i))) begin
                ent_d[i] = wr_byte;
            end else if (shift) begin
                ent_d[i] = moved_in;
            end else begin
                ent_d[i] = ent_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
            level_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= ent_d[i];
            end
            level_q <= level_q + LVLW'(accepted) - LVLW'(shift);
            ovf_q   <= wr_en && full;
        end
    end

    assign level = level_q;
    assign head  = ent_q[0];
    assign ovf   = ovf_q;
endmodule

// File: rtl/msgin_snoop.sv
module msgin_snoop #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accepted,
    input  logic [1:0]   wr_action,
    input  logic         copy_first,
    input  logic         latch_last,
    input  logic [W-1:0] head,
    input  logic         msgin_phase,
    output logic [1:0]   action,
    output logic [W-1:0] first_byte,
    output logic [W-1:0] last_byte,
    output logic [W-1:0] bus_data
);
    logic [1:0]   action_q;
    logic [W-1:0] first_q;
    logic [W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            action_q <= msgin_pkg::ACT_COMMAND;
            first_q  <= '0;
            last_q   <= '0;
        end else begin
            if (accepted) begin
                action_q <= wr_action;
            end
            if (copy_first) begin
                first_q <= head;
            end
            if (latch_last) begin
                last_q <= head;
            end
        end
    end

    assign action     = action_q;
    assign first_byte = first_q;
    assign last_byte  = last_q;
    assign bus_data   = msgin_phase ? head : '0;
endmodule

// File: rtl/msgin_seq.sv
module msgin_seq
    import msgin_pkg::*;
#(
    parameter int W    = 8,
    parameter int LENW = 4,
    parameter int LVLW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_valid,
    input  logic [W-1:0]    push_byte,
    input  logic [1:0]      push_action,
    input  logic            status_req,
    input  logic            defer_req,
    input  logic            xfer_req,
    input  logic [LENW-1:0] xfer_len,
    input  logic [LVLW-1:0] level,
    output logic            wr_en,
    output logic [W-1:0]    wr_byte,
    output logic [1:0]      wr_action,
    output logic            shift,
    output logic            copy_first,
    output logic            latch_last,
    output logic            out_valid,
    output logic            xfer_done,
    output logic            phase_valid,
    output logic [LVLW-1:0] moved
);
    seq_state_e      state_q, state_d;
    logic [LVLW-1:0] rem_q;
    logic [LVLW-1:0] moved_q;
    logic [LVLW-1:0] take;
    logic            accept_xfer;

    assign take        = (xfer_len < LENW'(level)) ? LVLW'(xfer_len) : level;
    assign accept_xfer = (state_q == ST_IDLE) && !defer_req && !status_req && xfer_req;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (defer_req) begin
                    state_d = ST_DEFER2;
                end else if (accept_xfer) begin
                    state_d = (take == '0) ? ST_DONE : ST_XFER;
                end
            end
            ST_DEFER2: state_d = ST_IDLE;
            ST_XFER: begin
                if (rem_q == LVLW'(1)) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_en       = 1'b0;
        wr_byte     = push_byte;
        wr_action   = push_action;
        shift       = 1'b0;
        copy_first  = 1'b0;
        latch_last  = 1'b0;
        out_valid   = 1'b0;
        xfer_done   = 1'b0;
        phase_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (defer_req) begin
                    wr_en     = 1'b1;
                    wr_byte   = W'(MSG_SAVE_PTR);
                    wr_action = ACT_DISCONN;
                end else if (status_req) begin
                    wr_en     = 1'b1;
                    wr_byte   = W'(MSG_COMPLETE);
                    wr_action = ACT_DISCONN;
                end else begin
                    wr_en      = push_valid;
                    copy_first = xfer_req;
                end
            end
            ST_DEFER2: begin
                wr_en     = 1'b1;
                wr_byte   = W'(MSG_DISCONN);
                wr_action = ACT_DISCONN;
            end
            ST_XFER: begin
                wr_en      = push_valid;
                out_valid  = 1'b1;
                shift      = 1'b1;
                latch_last = (rem_q == LVLW'(1));
            end
            ST_DONE: begin
                wr_en       = push_valid;
                xfer_done   = 1'b1;
                phase_valid = (level == '0);
            end
            default: ;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            moved_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept_xfer) begin
                rem_q   <= take;
                moved_q <= take;
            end else if (state_q == ST_XFER) begin
                rem_q <= rem_q - LVLW'(1);
            end
        end
    end

    assign moved = moved_q;
endmodule

// File: rtl/msgin_queue.sv
module msgin_queue #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int LENW  = 4,
    parameter int LVLW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_valid,
    input  logic [W-1:0]    push_byte,
    input  logic [1:0]      push_action,
    input  logic            status_req,
    input  logic            defer_req,
    input  logic            xfer_req,
    input  logic [LENW-1:0] xfer_len,
    input  logic            msgin_phase,
    output logic            out_valid,
    output logic [W-1:0]    out_byte,
    output logic            xfer_done,
    output logic [LVLW-1:0] moved,
    output logic            phase_valid,
    output logic [1:0]      next_phase,
    output logic [W-1:0]    first_byte,
    output logic [W-1:0]    last_byte,
    output logic [W-1:0]    bus_data,
    output logic [LVLW-1:0] level,
    output logic            overflow
);
    logic         wr_en;
    logic [W-1:0] wr_byte;
    logic [1:0]   wr_action;
    logic         shift;
    logic         copy_first;
    logic         latch_last;
    logic         accepted;
    logic [W-1:0] head;

    msgin_seq #(.W(W), .LENW(LENW), .LVLW(LVLW)) i_seq (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_byte(push_byte), .push_action(push_action),
        .status_req(status_req), .defer_req(defer_req),
        .xfer_req(xfer_req), .xfer_len(xfer_len), .level(level),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_action(wr_action),
        .shift(shift), .copy_first(copy_first), .latch_last(latch_last),
        .out_valid(out_valid), .xfer_done(xfer_done),
        .phase_valid(phase_valid), .moved(moved)
    );

    msgin_store #(.DEPTH(DEPTH), .W(W), .LVLW(LVLW)) i_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_byte(wr_byte), .shift(shift),
        .level(level), .head(head), .accepted(accepted), .ovf(overflow)
    );

    msgin_snoop #(.W(W)) i_snoop (
        .clk(clk), .rst_n(rst_n),
        .accepted(accepted), .wr_action(wr_action),
        .copy_first(copy_first), .latch_last(latch_last),
        .head(head), .msgin_phase(msgin_phase),
        .action(next_phase), .first_byte(first_byte),
        .last_byte(last_byte), .bus_data(bus_data)
    );

    assign out_byte = head;
endmodule

// File: rtl/msgin_queue_chk.sv
module msgin_queue_chk #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int LVLW  = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [LVLW-1:0] level,
    input logic            overflow,
    input logic            wr_en,
    input logic            accepted,
    input logic            shift,
    input logic            out_valid,
    input logic            xfer_done,
    input logic            phase_valid,
    input logic            msgin_phase,
    input logic [W-1:0]    bus_data
);
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVLW'(DEPTH));

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (level == LVLW'(DEPTH)) && !shift) |=> (overflow && level == $past(level)));

    assert_shift_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !accepted) |=> (level == $past(level) - LVLW'(1)));

    assert_stream_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (level != '0));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    assert_phase_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase_valid |-> (xfer_done && level == '0));

    assert_bus_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !msgin_phase |-> (bus_data == '0));
endmodule

bind msgin_queue msgin_queue_chk #(.DEPTH(DEPTH), .W(W), .LVLW(LVLW)) i_chk (
    .clk(clk), .rst_n(rst_n), .level(level), .overflow(overflow),
    .wr_en(wr_en), .accepted(accepted), .shift(shift),
    .out_valid(out_valid), .xfer_done(xfer_done), .phase_valid(phase_valid),
    .msgin_phase(msgin_phase), .bus_data(bus_data)
);

// File: tb/test_msgin_queue.sv
`timescale 1ns/1ps
module test_msgin_queue;
    localparam int DEPTH = 8;
    localparam int W     = 8;
    localparam int LENW  = 4;
    localparam int LVLW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic            push_valid = 1'b0;
    logic [W-1:0]    push_byte = '0;
    logic [1:0]      push_action = '0;
    logic            status_req = 1'b0;
    logic            defer_req = 1'b0;
    logic            xfer_req = 1'b0;
    logic [LENW-1:0] xfer_len = '0;
    logic            msgin_phase = 1'b0;
    logic            out_valid;
    logic [W-1:0]    out_byte;
    logic            xfer_done;
    logic [LVLW-1:0] moved;
    logic            phase_valid;
    logic [1:0]      next_phase;
    logic [W-1:0]    first_byte;
    logic [W-1:0]    last_byte;
    logic [W-1:0]    bus_data;
    logic [LVLW-1:0] level;
    logic            overflow;

    always #4 clk = ~clk;

    msgin_queue #(.DEPTH(DEPTH), .W(W), .LENW(LENW)) i_msgin_queue (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_byte(push_byte), .push_action(push_action),
        .status_req(status_req), .defer_req(defer_req),
        .xfer_req(xfer_req), .xfer_len(xfer_len), .msgin_phase(msgin_phase),
        .out_valid(out_valid), .out_byte(out_byte), .xfer_done(xfer_done),
        .moved(moved), .phase_valid(phase_valid), .next_phase(next_phase),
        .first_byte(first_byte), .last_byte(last_byte), .bus_data(bus_data),
        .level(level), .overflow(overflow)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] q[$];
    logic [1:0] act_m = 2'd0;
    logic [7:0] last_m = 8'd0;
    logic [7:0] first_m = 8'd0;
    bit exp_ovf = 1'b0;

    task automatic chk(string rq, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int exp_bus();
        if (!msgin_phase) return 0;
        return (q.size() > 0) ? int'(q[0]) : 0;
    endfunction

    function automatic int min2(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic model_write(logic [7:0] b, logic [1:0] a);
        if (q.size() == DEPTH) exp_ovf = 1'b1;
        else begin
            q.push_back(b);
            act_m = a;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk("R1 overflow", int'(overflow), int'(exp_ovf));
        exp_ovf = 1'b0;
        chk("R3 level", int'(level), q.size());
        chk("R5 bus_data", int'(bus_data), exp_bus());
        chk("R13 action", int'(next_phase), int'(act_m));
        chk("R4 last_byte", int'(last_byte), int'(last_m));
        chk("R9 first_byte", int'(first_byte), int'(first_m));
    endtask

    task automatic push_op(logic [7:0] b, logic [1:0] a);
        push_valid = 1'b1; push_byte = b; push_action = a;
        model_write(b, a);
        tick();
        push_valid = 1'b0;
    endtask

    // R7 / R11: status request, optionally colliding with a push and a transfer
    task automatic status_op(bit with_push, bit with_xfer);
        status_req = 1'b1;
        push_valid = with_push; push_byte = 8'hA5; push_action = 2'd3;
        xfer_req = with_xfer; xfer_len = 4'd3;
        model_write(8'h00, 2'd1);
        tick();
        status_req = 1'b0; push_valid = 1'b0; xfer_req = 1'b0;
        chk("R11 xfer ignored under status", int'(out_valid), 0);
        chk("R11 no done under status", int'(xfer_done), 0);
    endtask

    // R8 / R11: defer sequence, optionally with status and push held both cycles
    task automatic defer_op(bit with_push, bit with_status);
        defer_req = 1'b1; status_req = with_status;
        push_valid = with_push; push_byte = 8'h5A; push_action = 2'd2;
        model_write(8'h02, 2'd1);
        tick();
        defer_req = 1'b0;
        model_write(8'h04, 2'd1);
        tick();
        push_valid = 1'b0; status_req = 1'b0;
    endtask

    // R2 R3 R4 R6 R9 R12: transfer with optional concurrent pushes
    task automatic xfer_op(int len, int push_pct, bit push_at_req);
        int take;
        take = min2(len, q.size());
        xfer_req = 1'b1; xfer_len = LENW'(len);
        first_m = (q.size() > 0) ? q[0] : 8'd0;
        if (push_at_req) begin
            push_valid = 1'b1; push_byte = 8'($urandom); push_action = 2'($urandom);
            model_write(push_byte, push_action);
        end
        tick();
        xfer_req = 1'b0; push_valid = 1'b0;
        for (int k = 0; k < take; k++) begin
            int lvl;
            logic [7:0] b;
            chk("R2 out_valid", int'(out_valid), 1);
            chk("R3 order", int'(out_byte), int'(q[0]));
            lvl = q.size();
            b = q.pop_front();
            if (k == take - 1) last_m = b;
            if (($urandom % 100) < push_pct) begin
                push_valid = 1'b1; push_byte = 8'($urandom); push_action = 2'($urandom);
                if (lvl == DEPTH) exp_ovf = 1'b1;
                else begin
                    q.push_back(push_byte);
                    act_m = push_action;
                end
            end
            tick();
            push_valid = 1'b0;
        end
        chk("R2 done", int'(xfer_done), 1);
        chk("R2 moved", int'(moved), take);
        chk("R2 out_valid low in done", int'(out_valid), 0);
        chk("R6 phase_valid", int'(phase_valid), (q.size() == 0) ? 1 : 0);
        tick();
        chk("R2 done single cycle", int'(xfer_done), 0);
        chk("R6 phase_valid low", int'(phase_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        msgin_phase = 1'b1;
        #1;
        // R10 reset state
        chk("R10 level", int'(level), 0);
        chk("R10 action", int'(next_phase), 0);
        chk("R10 first", int'(first_byte), 0);
        chk("R10 last", int'(last_byte), 0);
        chk("R10 strobes", int'({out_valid, xfer_done, phase_valid, overflow}), 0);
        chk("R10 bus_data empty", int'(bus_data), 0);

        // R2 zero-length transfer on empty queue, R6 phase with action 0
        xfer_op(0, 0, 1'b0);
        // R1 fill to 8, then overflow
        for (int i = 0; i < DEPTH; i++) push_op(8'(8'h10 + i), 2'd2);
        push_op(8'hEE, 2'd3);
        status_op(1'b0, 1'b0);
        // R12 full queue, pushes every streaming cycle; first one overflows
        xfer_op(3, 100, 1'b0);
        // R2 request larger than level
        xfer_op(15, 0, 1'b0);
        // R12 push in the request cycle on an empty queue: take 0
        xfer_op(4, 0, 1'b1);
        xfer_op(4, 0, 1'b0);
        // R11 collisions
        status_op(1'b1, 1'b1);
        defer_op(1'b1, 1'b1);
        msgin_phase = 1'b0;
        xfer_op(2, 0, 1'b0);
        msgin_phase = 1'b1;
        xfer_op(15, 0, 1'b0);
        // R6 each action code selects its phase
        for (int a = 0; a < 4; a++) begin
            push_op(8'(8'h40 + a), 2'(a));
            xfer_op(1, 0, 1'b0);
            chk("R6 next_phase code", int'(next_phase), a);
        end
        // R8 defer then drain
        defer_op(1'b0, 1'b0);
        xfer_op(2, 0, 1'b0);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int sel;
            sel = int'($urandom % 100);
            msgin_phase = 1'($urandom);
            if (sel < 40) push_op(8'($urandom), 2'($urandom));
            else if (sel < 48) status_op(1'($urandom), 1'($urandom));
            else if (sel < 56) defer_op(1'($urandom), 1'($urandom));
            else xfer_op(int'($urandom % 11), 30, 1'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule